// File: doc/BRIEF.md
# Dual-Issue In-Order Pairing Logic

This block sits between a decoded-instruction queue and two execution pipes plus one memory pipe. Each cycle it looks at the two oldest queue entries and decides how many of them may leave the queue: zero, only the older one, or both. It checks each source operand against a per-register countdown scoreboard. It checks the pair against itself for structural clashes, same-cycle dependencies and destination collisions. It then assigns each issuing instruction to a pipe. The multiplier exists only in pipe 0, so a younger multiply can push an older ALU operation into pipe 1.

Every memory operation that issues is also written into a small replay buffer. The buffer holds each operation until the memory side reports it complete. When the memory side reports a stall, every buffered operation is sent again, oldest first, on a dedicated replay output. While this sweep runs it occupies the memory pipe. The issue decision, the pipe codes and the pop count are combinational, so the queue can advance in the same cycle. The scoreboard and the replay buffer are the only state.

Top module: `dual_issue_pairing`

## Requirements
- R1: Issue is in order. The younger slot never issues unless the older slot issues in the same cycle, and pop_cnt always equals the number of slots issued. An invalid older slot blocks both slots.
- R2: A register written by an issued instruction becomes readable by a later instruction at a fixed distance. For an ALU producer it is the next cycle, for a load two cycles later, and for a multiply three cycles later. An instruction whose source is still pending does not issue. Class codes are 0 ALU, 1 multiply, 2 load and 3 store, and a store writes no register.
- R3: Pipe codes are 0 for pipe 0 (ALU or multiply), 1 for pipe 1 (ALU only) and 2 for the memory pipe. Loads and stores go to code 2 and multiplies to code 0. The older ALU operation takes code 1 only when the younger issuing instruction is a multiply. A younger ALU operation takes whichever of codes 0 and 1 the older slot left free.
- R4: A pair of two multiplies, or a pair of two memory operations, issues only the older instruction.
- R5: When the younger instruction reads the older one's destination, both issue together only if the older one is an ALU operation and fwd_ok is 1. Otherwise only the older one issues.
- R6: When both instructions of a pair write the same register, only the older one issues.
- R7: Every issued load or store enters the replay buffer with its tag. A mem_done pulse retires the oldest entry.
- R8: A mem_stall pulse with a non-empty buffer starts a sweep in the next cycle. The sweep presents each buffered tag once on rply_tag with rply_vld high, oldest first, one per cycle. No entry is removed, and no new memory operation issues while it runs.
- R9: While the replay buffer holds RB_DEPTH (4) entries, neither slot issues.
- R10: mem_stall and mem_done have no effect during a sweep. mem_stall has no effect on an empty buffer. mem_done in the same cycle as an accepted mem_stall is ignored.
- R11: After reset no slot issues while the queue is empty, the replay output is idle, and every register reads as available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_vld | input | 1 | Older queue entry present |
| s0_cls | input | 2 | Older entry class (0 ALU, 1 MUL, 2 LOAD, 3 STORE) |
| s0_dst | input | REG_W | Older entry destination register |
| s0_sra | input | REG_W | Older entry first source register |
| s0_srb | input | REG_W | Older entry second source register |
| s0_tag | input | TAG_W | Older entry identifier |
| s1_vld | input | 1 | Younger queue entry present |
| s1_cls | input | 2 | Younger entry class |
| s1_dst | input | REG_W | Younger entry destination register |
| s1_sra | input | REG_W | Younger entry first source register |
| s1_srb | input | REG_W | Younger entry second source register |
| s1_tag | input | TAG_W | Younger entry identifier |
| fwd_ok | input | 1 | Same-cycle bypass path available this cycle |
| mem_stall | input | 1 | Memory side dropped its outstanding operations |
| mem_done | input | 1 | Memory side completed the oldest outstanding operation |
| iss0_vld | output | 1 | Older entry issues this cycle |
| iss0_pipe | output | 2 | Pipe code for the older entry |
| iss1_vld | output | 1 | Younger entry issues this cycle |
| iss1_pipe | output | 2 | Pipe code for the younger entry |
| pop_cnt | output | 2 | Entries to remove from the queue head |
| rply_vld | output | 1 | A replayed memory operation is presented |
| rply_tag | output | TAG_W | Identifier of the replayed operation |

## Verification
The checker relies on the queue keeping the older entry in slot 0, and on a slot that is not valid carrying no meaning. It also relies on mem_stall and mem_done being single-cycle reports that may arrive at any time. The block defines their effect during a sweep as none, so the checker needs no restriction there. The stimulus keeps sources and destinations in disjoint register ranges unless a row exercises a dependency or collision on purpose. Idle cycles with mem_done high separate the table rows, so every row starts with an idle scoreboard and an empty replay buffer. The replay sequence deliberately raises mem_stall and mem_done inside a sweep and on an empty buffer to exercise the ignore rules.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  typedef enum logic [1:0] {
    CL_ALU   = 2'd0,
    CL_MUL   = 2'd1,
    CL_LOAD  = 2'd2,
    CL_STORE = 2'd3
  } op_class_e;

  typedef enum logic [1:0] {
    PIPE_A   = 2'd0,
    PIPE_B   = 2'd1,
    PIPE_MEM = 2'd2
  } pipe_e;

  function automatic logic is_mem(op_class_e c);
    return (c == CL_LOAD) || (c == CL_STORE);
  endfunction

  function automatic logic writes_reg(op_class_e c);
    return c != CL_STORE;
  endfunction

endpackage

// File: rtl/dual_issue_scoreboard.sv
module dual_issue_scoreboard
  import dual_issue_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int REG_W    = $clog2(NREG),
  parameter int NQ       = 4,
  parameter int LAT_ALU  = 1,
  parameter int LAT_LOAD = 2,
  parameter int LAT_MUL  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr0_en,
  input  logic [REG_W-1:0]         wr0_reg,
  input  op_class_e                wr0_cls,
  input  logic                     wr1_en,
  input  logic [REG_W-1:0]         wr1_reg,
  input  op_class_e                wr1_cls,
  input  logic [NQ-1:0][REG_W-1:0] q_reg,
  output logic [NQ-1:0]            q_rdy
);

  localparam int CW = $clog2(LAT_MUL + 1);

  logic [CW-1:0] cnt [NREG];

  function automatic logic [CW-1:0] wait_of(op_class_e c);
    case (c)
      CL_MUL:  return CW'(LAT_MUL - 1);
      CL_LOAD: return CW'(LAT_LOAD - 1);
      default: return CW'(LAT_ALU - 1);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (rst) begin
        cnt[r] <= '0;
      end else if (wr1_en && wr1_reg == REG_W'(r)) begin
        cnt[r] <= wait_of(wr1_cls);
      end else if (wr0_en && wr0_reg == REG_W'(r)) begin
        cnt[r] <= wait_of(wr0_cls);
      end else if (cnt[r] != '0) begin
        cnt[r] <= cnt[r] - CW'(1);
      end
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_query
    assign q_rdy[q] = (cnt[q_reg[q]] == '0);
  end

endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check
  import dual_issue_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic             s0_vld,
  input  op_class_e        s0_cls,
  input  logic [REG_W-1:0] s0_dst,
  input  logic             s1_vld,
  input  op_class_e        s1_cls,
  input  logic [REG_W-1:0] s1_dst,
  input  logic [REG_W-1:0] s1_sra,
  input  logic [REG_W-1:0] s1_srb,
  input  logic [3:0]       src_rdy,
  input  logic             fwd_ok,
  input  logic             ls_busy,
  input  logic             rb_full,
  output logic             go0,
  output logic             go1,
  output pipe_e            pipe0,
  output pipe_e            pipe1
);

  logic mem0, mem1, wr0, wr1;
  logic hit_a, hit_b, bypass, ok_a, ok_b, waw, clash;

  always_comb begin
    mem0   = is_mem(s0_cls);
    mem1   = is_mem(s1_cls);
    wr0    = writes_reg(s0_cls);
    wr1    = writes_reg(s1_cls);
    go0    = s0_vld && !rb_full && src_rdy[0] && src_rdy[1] && !(mem0 && ls_busy);

    hit_a  = wr0 && (s1_sra == s0_dst);
    hit_b  = wr0 && (s1_srb == s0_dst);
    bypass = (s0_cls == CL_ALU) && fwd_ok;
    ok_a   = hit_a ? bypass : src_rdy[2];
    ok_b   = hit_b ? bypass : src_rdy[3];
    waw    = wr0 && wr1 && (s0_dst == s1_dst);
    clash  = ((s0_cls == CL_MUL) && (s1_cls == CL_MUL)) || (mem0 && mem1);
    go1    = go0 && s1_vld && ok_a && ok_b && !waw && !clash && !(mem1 && ls_busy);

    if (!go0)                                               pipe0 = PIPE_A;
    else if (mem0)                                          pipe0 = PIPE_MEM;
    else if (s0_cls == CL_ALU && go1 && s1_cls == CL_MUL)   pipe0 = PIPE_B;
    else                                                    pipe0 = PIPE_A;

    if (!go1)                     pipe1 = PIPE_A;
    else if (mem1)                pipe1 = PIPE_MEM;
    else if (s1_cls == CL_MUL)    pipe1 = PIPE_A;
    else if (pipe0 == PIPE_A && !mem0) pipe1 = PIPE_B;
    else                          pipe1 = PIPE_A;
  end

endmodule

// File: rtl/dual_issue_replay_buf.sv
module dual_issue_replay_buf #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 6,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             done,
  input  logic             stall,
  output logic             full,
  output logic             sweep,
  output logic [TAG_W-1:0] rply_tag,
  output logic [AW:0]      level
);

  localparam logic [AW:0] ONE  = (AW+1)'(1);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [TAG_W-1:0] store [DEPTH];
  logic [AW:0]      wr_ptr, rd_ptr, rp_ptr;
  logic             empty, take_done, start, last;

  assign level     = wr_ptr - rd_ptr;
  assign empty     = (level == '0);
  assign full      = (level == FULL);
  assign take_done = done && !stall && !sweep && !empty;
  assign start     = stall && !sweep && !empty;
  assign last      = (rp_ptr + ONE) == wr_ptr;
  assign rply_tag  = store[rp_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr[AW-1:0]] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      rp_ptr <= '0;
      sweep  <= 1'b0;
    end else begin
      if (push)      wr_ptr <= wr_ptr + ONE;
      if (take_done) rd_ptr <= rd_ptr + ONE;
      if (start) begin
        sweep  <= 1'b1;
        rp_ptr <= rd_ptr;
      end else if (sweep) begin
        if (last) sweep  <= 1'b0;
        else      rp_ptr <= rp_ptr + ONE;
      end
    end
  end

endmodule

// File: rtl/dual_issue_pairing.sv
module dual_issue_pairing
  import dual_issue_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int REG_W    = $clog2(NREG),
  parameter int TAG_W    = 6,
  parameter int RB_DEPTH = 4,
  parameter int LAT_ALU  = 1,
  parameter int LAT_LOAD = 2,
  parameter int LAT_MUL  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s0_vld,
  input  logic [1:0]       s0_cls,
  input  logic [REG_W-1:0] s0_dst,
  input  logic [REG_W-1:0] s0_sra,
  input  logic [REG_W-1:0] s0_srb,
  input  logic [TAG_W-1:0] s0_tag,
  input  logic             s1_vld,
  input  logic [1:0]       s1_cls,
  input  logic [REG_W-1:0] s1_dst,
  input  logic [REG_W-1:0] s1_sra,
  input  logic [REG_W-1:0] s1_srb,
  input  logic [TAG_W-1:0] s1_tag,
  input  logic             fwd_ok,
  input  logic             mem_stall,
  input  logic             mem_done,
  output logic             iss0_vld,
  output logic [1:0]       iss0_pipe,
  output logic             iss1_vld,
  output logic [1:0]       iss1_pipe,
  output logic [1:0]       pop_cnt,
  output logic             rply_vld,
  output logic [TAG_W-1:0] rply_tag
);

  localparam int RB_AW = $clog2(RB_DEPTH);

  op_class_e               c0, c1;
  pipe_e                   pipe0, pipe1;
  logic                    go0, go1, rb_full, sweep, push;
  logic [3:0][REG_W-1:0]   q_reg;
  logic [3:0]              q_rdy;
  logic [TAG_W-1:0]        push_tag;
  logic [RB_AW:0]          rb_cnt;

  assign c0    = op_class_e'(s0_cls);
  assign c1    = op_class_e'(s1_cls);
  assign q_reg = {s1_srb, s1_sra, s0_srb, s0_sra};

  dual_issue_scoreboard #(
    .NREG(NREG), .REG_W(REG_W), .NQ(4),
    .LAT_ALU(LAT_ALU), .LAT_LOAD(LAT_LOAD), .LAT_MUL(LAT_MUL)
  ) u_sb (
    .clk(clk), .rst(rst),
    .wr0_en(go0 && writes_reg(c0)), .wr0_reg(s0_dst), .wr0_cls(c0),
    .wr1_en(go1 && writes_reg(c1)), .wr1_reg(s1_dst), .wr1_cls(c1),
    .q_reg(q_reg), .q_rdy(q_rdy)
  );

  dual_issue_pair_check #(.REG_W(REG_W)) u_pair (
    .s0_vld(s0_vld), .s0_cls(c0), .s0_dst(s0_dst),
    .s1_vld(s1_vld), .s1_cls(c1), .s1_dst(s1_dst),
    .s1_sra(s1_sra), .s1_srb(s1_srb),
    .src_rdy(q_rdy), .fwd_ok(fwd_ok), .ls_busy(sweep), .rb_full(rb_full),
    .go0(go0), .go1(go1), .pipe0(pipe0), .pipe1(pipe1)
  );

  assign push     = (go0 && is_mem(c0)) || (go1 && is_mem(c1));
  assign push_tag = (go0 && is_mem(c0)) ? s0_tag : s1_tag;

  dual_issue_replay_buf #(.DEPTH(RB_DEPTH), .TAG_W(TAG_W)) u_rb (
    .clk(clk), .rst(rst),
    .push(push), .push_tag(push_tag),
    .done(mem_done), .stall(mem_stall),
    .full(rb_full), .sweep(sweep), .rply_tag(rply_tag), .level(rb_cnt)
  );

  assign iss0_vld  = go0;
  assign iss1_vld  = go1;
  assign iss0_pipe = pipe0;
  assign iss1_pipe = pipe1;
  assign pop_cnt   = {1'b0, go0} + {1'b0, go1};
  assign rply_vld  = sweep;

endmodule

// File: rtl/dual_issue_pairing_chk.sv
module dual_issue_pairing_chk #(
  parameter int REG_W    = 4,
  parameter int RB_DEPTH = 4,
  parameter int RB_AW    = $clog2(RB_DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             s0_vld,
  input logic [1:0]       s0_cls,
  input logic [REG_W-1:0] s0_dst,
  input logic [REG_W-1:0] s0_sra,
  input logic [REG_W-1:0] s0_srb,
  input logic [1:0]       s1_cls,
  input logic [REG_W-1:0] s1_sra,
  input logic [REG_W-1:0] s1_srb,
  input logic             fwd_ok,
  input logic             iss0_vld,
  input logic [1:0]       iss0_pipe,
  input logic             iss1_vld,
  input logic [1:0]       iss1_pipe,
  input logic             rply_vld,
  input logic [RB_AW:0]   rb_cnt
);

  logic mem0, mem1, dep;
  assign mem0 = s0_cls[1];
  assign mem1 = s1_cls[1];
  assign dep  = (s0_cls != 2'd3) && (s1_sra == s0_dst || s1_srb == s0_dst);

  p_in_order_r1: assert property (@(posedge clk) disable iff (rst)
    iss1_vld |-> (iss0_vld && s0_vld));

  p_load_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (iss0_vld && s0_cls == 2'd2) |=>
      !(iss0_vld && (s0_sra == $past(s0_dst) || s0_srb == $past(s0_dst))));

  p_mul_pipe0_r3: assert property (@(posedge clk) disable iff (rst)
    ((iss0_vld && s0_cls == 2'd1) |-> iss0_pipe == 2'd0) and
    ((iss1_vld && s1_cls == 2'd1) |-> iss1_pipe == 2'd0));

  p_no_double_r4: assert property (@(posedge clk) disable iff (rst)
    iss1_vld |-> !(s0_cls == 2'd1 && s1_cls == 2'd1) && !(mem0 && mem1));

  p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    (iss1_vld && dep) |-> (s0_cls == 2'd0 && fwd_ok));

  p_sweep_blocks_mem_r8: assert property (@(posedge clk) disable iff (rst)
    rply_vld |-> !(iss0_vld && mem0) && !(iss1_vld && mem1));

  p_full_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rb_cnt == (RB_AW+1)'(RB_DEPTH)) |-> !iss0_vld);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    rb_cnt <= (RB_AW+1)'(RB_DEPTH));

endmodule

bind dual_issue_pairing dual_issue_pairing_chk #(.REG_W(REG_W), .RB_DEPTH(RB_DEPTH)) u_chk (
  .clk(clk), .rst(rst),
  .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_dst(s0_dst), .s0_sra(s0_sra), .s0_srb(s0_srb),
  .s1_cls(s1_cls), .s1_sra(s1_sra), .s1_srb(s1_srb),
  .fwd_ok(fwd_ok),
  .iss0_vld(iss0_vld), .iss0_pipe(iss0_pipe),
  .iss1_vld(iss1_vld), .iss1_pipe(iss1_pipe),
  .rply_vld(rply_vld), .rb_cnt(rb_cnt)
);

// File: tb/dual_issue_pairing_bench.sv
module dual_issue_pairing_bench;

  localparam int PERIOD = 8;
  localparam int RW = 4;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst;
  logic s0_vld, s1_vld, fwd_ok, mem_stall, mem_done;
  logic [1:0] s0_cls, s1_cls;
  logic [RW-1:0] s0_dst, s0_sra, s0_srb, s1_dst, s1_sra, s1_srb;
  logic [TW-1:0] s0_tag, s1_tag;
  logic iss0_vld, iss1_vld, rply_vld;
  logic [1:0] iss0_pipe, iss1_pipe, pop_cnt;
  logic [TW-1:0] rply_tag;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  dual_issue_pairing u_dual_issue_pairing (
    .clk(clk), .rst(rst),
    .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_dst(s0_dst), .s0_sra(s0_sra), .s0_srb(s0_srb), .s0_tag(s0_tag),
    .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_dst(s1_dst), .s1_sra(s1_sra), .s1_srb(s1_srb), .s1_tag(s1_tag),
    .fwd_ok(fwd_ok), .mem_stall(mem_stall), .mem_done(mem_done),
    .iss0_vld(iss0_vld), .iss0_pipe(iss0_pipe), .iss1_vld(iss1_vld), .iss1_pipe(iss1_pipe),
    .pop_cnt(pop_cnt), .rply_vld(rply_vld), .rply_tag(rply_tag)
  );

  // row: s0{v,cls,dst,a,b} s1{v,cls,dst,a,b} fwd exp0 exp1 pipe0 pipe1
  function automatic logic [36:0] mk(int v0, int c0, int d0, int a0, int b0,
                                     int v1, int c1, int d1, int a1, int b1,
                                     int f, int e0, int e1, int p0, int p1);
    return {1'(v0), 2'(c0), 4'(d0), 4'(a0), 4'(b0),
            1'(v1), 2'(c1), 4'(d1), 4'(a1), 4'(b1),
            1'(f), 1'(e0), 1'(e1), 2'(p0), 2'(p1)};
  endfunction

  localparam int NROW = 14;
  localparam logic [36:0] TBL [NROW] = '{
    mk(1,0,8,1,2, 1,0,9,3,4, 1, 1,1,0,1),  // R3 ALU+ALU
    mk(1,0,8,1,2, 1,1,9,3,4, 1, 1,1,1,0),  // R3 ALU+MUL swaps pipes
    mk(1,1,8,1,2, 1,0,9,3,4, 1, 1,1,0,1),  // R3 MUL+ALU
    mk(1,2,8,1,2, 1,0,9,3,4, 1, 1,1,2,0),  // R3 LOAD+ALU
    mk(1,0,8,1,2, 1,3,9,3,4, 1, 1,1,0,2),  // R3 ALU+STORE
    mk(1,1,8,1,2, 1,1,9,3,4, 1, 1,0,0,0),  // R4 MUL+MUL
    mk(1,2,8,1,2, 1,3,9,3,4, 1, 1,0,2,0),  // R4 LOAD+STORE
    mk(1,0,8,1,2, 1,0,9,8,4, 1, 1,1,0,1),  // R5 bypass allowed
    mk(1,0,8,1,2, 1,0,9,8,4, 0, 1,0,0,0),  // R5 bypass unavailable
    mk(1,2,8,1,2, 1,0,9,3,8, 1, 1,0,2,0),  // R5 load producer
    mk(1,0,8,1,2, 1,0,8,3,4, 1, 1,0,0,0),  // R6 same destination
    mk(0,0,8,1,2, 1,0,9,3,4, 1, 0,0,0,0),  // R1 older absent
    mk(1,1,8,1,2, 1,3,9,8,3, 1, 1,0,0,0),  // R5 multiply producer
    mk(1,3,8,1,2, 1,1,9,3,4, 1, 1,1,2,0)   // R3 STORE+MUL
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic idle();
    s0_vld = 0; s1_vld = 0; s0_cls = 0; s1_cls = 0;
    s0_dst = 0; s0_sra = 0; s0_srb = 0; s0_tag = 0;
    s1_dst = 0; s1_sra = 0; s1_srb = 0; s1_tag = 0;
    fwd_ok = 1; mem_stall = 0; mem_done = 0;
  endtask

  task automatic set0(int c, int d, int a, int b, int t);
    s0_vld = 1; s0_cls = 2'(c); s0_dst = 4'(d); s0_sra = 4'(a); s0_srb = 4'(b); s0_tag = 6'(t);
  endtask

  task automatic next();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin
      next(); idle(); mem_done = 1;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog R1..all actual=timeout expected=finished");
    summary();
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    next(); rst = 0;
    settle();
    // R11 reset state
    chk("R11 iss0_vld after reset", int'(iss0_vld), 0);
    chk("R11 iss1_vld after reset", int'(iss1_vld), 0);
    chk("R11 pop_cnt after reset", int'(pop_cnt), 0);
    chk("R11 rply_vld after reset", int'(rply_vld), 0);
    next(); set0(0, 15, 14, 13, 1); settle();
    chk("R11 all registers ready after reset", int'(iss0_vld), 1);
    drain(3);

    // table walk
    for (int r = 0; r < NROW; r++) begin
      logic [36:0] v;
      v = TBL[r];
      next();
      s0_vld = v[36]; s0_cls = v[35:34]; s0_dst = v[33:30]; s0_sra = v[29:26]; s0_srb = v[25:22];
      s1_vld = v[21]; s1_cls = v[20:19]; s1_dst = v[18:15]; s1_sra = v[14:11]; s1_srb = v[10:7];
      fwd_ok = v[6]; s0_tag = 6'(r); s1_tag = 6'(r + 32); mem_stall = 0; mem_done = 0;
      settle();
      chk($sformatf("R1/R3/R4/R5/R6 row %0d iss0_vld", r), int'(iss0_vld), int'(v[5]));
      chk($sformatf("R1/R3/R4/R5/R6 row %0d iss1_vld", r), int'(iss1_vld), int'(v[4]));
      chk($sformatf("R3 row %0d iss0_pipe", r), int'(iss0_pipe), int'(v[3:2]));
      chk($sformatf("R3 row %0d iss1_pipe", r), int'(iss1_pipe), int'(v[1:0]));
      chk($sformatf("R1 row %0d pop_cnt", r), int'(pop_cnt), int'(v[5]) + int'(v[4]));
      drain(3);
    end

    // R2 load latency
    next(); idle(); mem_done = 1; set0(2, 10, 1, 2, 1); settle();
    chk("R2 load issues", int'(iss0_vld), 1);
    next(); idle(); mem_done = 1; set0(0, 11, 10, 3, 2); settle();
    chk("R2 load consumer blocked one cycle later", int'(iss0_vld), 0);
    chk("R1 nothing popped while older blocked", int'(pop_cnt), 0);
    next(); settle();
    chk("R2 load consumer issues two cycles later", int'(iss0_vld), 1);
    drain(3);
    // R2 multiply latency
    next(); idle(); set0(1, 12, 1, 2, 3); settle();
    chk("R2 multiply issues", int'(iss0_vld), 1);
    next(); idle(); set0(0, 11, 3, 12, 4); settle();
    chk("R2 multiply consumer blocked at +1", int'(iss0_vld), 0);
    next(); settle();
    chk("R2 multiply consumer blocked at +2", int'(iss0_vld), 0);
    next(); settle();
    chk("R2 multiply consumer issues at +3", int'(iss0_vld), 1);
    drain(3);
    // R2 ALU back to back
    next(); idle(); set0(0, 13, 1, 2, 5); settle();
    chk("R2 ALU producer issues", int'(iss0_vld), 1);
    next(); idle(); set0(0, 14, 13, 13, 6); settle();
    chk("R2 ALU consumer issues next cycle", int'(iss0_vld), 1);
    drain(3);
    // R1 younger pending source while older ready
    next(); idle(); mem_done = 1; set0(2, 10, 1, 2, 7); settle();
    chk("R2 second load issues", int'(iss0_vld), 1);
    next(); idle(); mem_done = 1; set0(0, 13, 1, 2, 8);
    s1_vld = 1; s1_cls = 0; s1_dst = 14; s1_sra = 10; s1_srb = 3; settle();
    chk("R1 older issues alone", int'(iss0_vld), 1);
    chk("R2 younger waits on pending load", int'(iss1_vld), 0);
    chk("R1 pop_cnt one", int'(pop_cnt), 1);
    drain(4);

    // R7 R8 R9 R10 replay
    for (int i = 0; i < 3; i++) begin
      next(); idle(); set0(2, 8 + i, 1, 2, 5 + i); settle();
      chk("R7 load issues to memory pipe", int'(iss0_pipe), 2);
    end
    next(); idle(); mem_stall = 1; settle();
    chk("R8 sweep not yet visible in stall cycle", int'(rply_vld), 0);
    next(); idle(); mem_stall = 1; mem_done = 1; set0(2, 11, 1, 2, 9); settle();
    chk("R8 sweep first tag", int'(rply_tag), 5);
    chk("R8 sweep valid", int'(rply_vld), 1);
    chk("R8 memory op blocked during sweep", int'(iss0_vld), 0);
    next(); idle(); set0(2, 11, 1, 2, 9); settle();
    chk("R10 stall inside sweep ignored, second tag", int'(rply_tag), 6);
    chk("R8 memory op still blocked", int'(iss0_vld), 0);
    next(); settle();
    chk("R8 sweep third tag", int'(rply_tag), 7);
    next(); settle();
    chk("R8 sweep finished", int'(rply_vld), 0);
    chk("R8 memory op issues after sweep", int'(iss0_vld), 1);
    next(); idle(); set0(0, 12, 1, 2, 10); settle();
    chk("R9 full buffer holds issue", int'(iss0_vld), 0);
    chk("R10 done inside sweep ignored, entries kept", int'(pop_cnt), 0);
    next(); idle(); mem_done = 1; set0(0, 12, 1, 2, 10); settle();
    chk("R9 still full in retire cycle", int'(iss0_vld), 0);
    next(); idle(); set0(0, 12, 1, 2, 10); settle();
    chk("R9 issue resumes after retire", int'(iss0_vld), 1);
    next(); idle(); mem_stall = 1; mem_done = 1; settle();
    next(); idle(); settle();
    chk("R7 oldest retired, sweep starts at second tag", int'(rply_tag), 6);
    chk("R10 done with stall ignored", int'(rply_vld), 1);
    next(); settle();
    chk("R7 sweep order next tag", int'(rply_tag), 7);
    next(); settle();
    chk("R7 sweep order last tag", int'(rply_tag), 9);
    next(); settle();
    chk("R8 sweep ends after last entry", int'(rply_vld), 0);
    drain(5);
    next(); idle(); mem_stall = 1; settle();
    next(); idle(); set0(2, 8, 1, 2, 11); settle();
    chk("R10 stall on empty buffer has no sweep", int'(rply_vld), 0);
    chk("R10 memory op issues after empty stall", int'(iss0_vld), 1);
    drain(2);
    summary();
  end

endmodule